// File: doc/BRIEF.md
# TFT Panel Control Strobe Generator

This block drives the two extra per-line control strobes and the pixel shift clock that a particular class of TFT panel expects. It runs on the system clock and advances once per pixel, marked by a pixel-clock enable. A line-start pulse, given on a pixel cycle, resets an internal pixel offset counter. Each strobe is high over a window of offsets, from a programmed start value to a programmed stop value. The line and frame timing, the pixel data and the register decode all sit outside the block.

The first strobe (line strobe) follows its window in window mode. In toggle mode it inverts once per line instead. The second strobe (polarity strobe) always follows its window. A preset enable gates both windows. A swap bit exchanges the pins that carry the two strobes. The shift clock goes high for one system-clock cycle after each pixel enable, and a polarity bit can invert it. A mask bit can hold the shift clock at its idle level while the display-active flag is low.

All configuration inputs are captured on the line-start pixel, so a register write takes effect on a line boundary. The pixel enable must never be high on two consecutive system-clock cycles, so that the shift clock has a low phase. Before the first line start, both strobes stay low.

Top module: `tft_strobe_gen`

## Requirements
- R1: The pixel offset is 0 on the pixel cycle that carries line_start and rises by one on each later pixel cycle. It saturates at 1023 and holds there until the next line start.
- R2: With cls_window_mode=1 and preset_en=1, the line strobe is high for offsets cls_on_cfg through cls_off_cfg inclusive. That is (off - on + 1) pixels. Both strobe outputs change only on the system-clock edge that samples pix_en high.
- R3: With preset_en=1, the polarity strobe is high for offsets ps_on_cfg through ps_off_cfg inclusive.
- R4: With preset_en=0, the polarity strobe stays low, and so does the line strobe in window mode.
- R5: A window whose stop offset is below its start offset keeps its strobe low for the whole line.
- R6: With cls_window_mode=0, the line strobe inverts on each line-start pixel and holds its level for the rest of the line.
- R7: With swap_pins=0, ctl1_o carries the line strobe and ctl0_o carries the polarity strobe. With swap_pins=1, the two are exchanged.
- R8: With shift_invert=0, shift_clk_o is 1 for the single system-clock cycle after each pix_en cycle and 0 otherwise. With shift_invert=1, it is the complement.
- R9: With shift_gate_en=1 and disp_active=0, shift_clk_o rests at the level of shift_invert. With shift_gate_en=0, the shift clock keeps running while disp_active=0.
- R10: All configuration inputs are captured on the line-start pixel. A change made part way through a line has no effect until the next line start.
- R11: While reset is held, all three outputs are 0. After reset, pixels that arrive before the first line start leave both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable, one system cycle per pixel |
| line_start | input | 1 | Line-sync start, valid together with pix_en |
| disp_active | input | 1 | Horizontal display-active flag |
| cls_on_cfg | input | 10 | Line strobe start offset |
| cls_off_cfg | input | 10 | Line strobe stop offset |
| ps_on_cfg | input | 10 | Polarity strobe start offset |
| ps_off_cfg | input | 10 | Polarity strobe stop offset |
| cls_window_mode | input | 1 | 1: line strobe uses its window; 0: toggle per line |
| preset_en | input | 1 | Enables the programmed windows |
| swap_pins | input | 1 | Exchanges the two strobe pins |
| shift_invert | input | 1 | Inverts the shift clock |
| shift_gate_en | input | 1 | Masks the shift clock during blanking |
| ctl1_o | output | 1 | Control pin 1 |
| ctl0_o | output | 1 | Control pin 0 |
| shift_clk_o | output | 1 | Pixel shift clock |

## Verification
The window function is run over whole lines under several configurations: separated windows, windows at offset 0 and at the last pixel of a line, a reversed window, a disabled preset, repeated toggle-mode lines and both swap settings. Each one checks the strobe level at every pixel. Together these distinguish an off-by-one at the start or stop edge, a missing preset gate and a wrong pin assignment. A long line reaches the saturated offset and shows whether the counter wraps. A line with a mid-line configuration change shows whether the capture happens only at line start. Shift-clock cases cover each combination of polarity, mask and display-active that matters, and separate a running clock from one held at its idle level.

// File: rtl/tft_strobe_gen.sv
module tft_strobe_gen #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             line_start,
  input  logic             disp_active,
  input  logic [OFS_W-1:0] cls_on_cfg,
  input  logic [OFS_W-1:0] cls_off_cfg,
  input  logic [OFS_W-1:0] ps_on_cfg,
  input  logic [OFS_W-1:0] ps_off_cfg,
  input  logic             cls_window_mode,
  input  logic             preset_en,
  input  logic             swap_pins,
  input  logic             shift_invert,
  input  logic             shift_gate_en,
  output logic             ctl1_o,
  output logic             ctl0_o,
  output logic             shift_clk_o
);

  localparam logic [OFS_W-1:0] OFS_MAX = '1;

  logic [OFS_W-1:0] ofs_q, cls_on_q, cls_off_q, ps_on_q, ps_off_q;
  logic             mode_q, preset_q, swap_q, inv_q, mask_q;
  logic             cls_q, ps_q, shclk_q;

  logic             take;
  logic [OFS_W-1:0] ofs_now, e_cls_on, e_cls_off, e_ps_on, e_ps_off;
  logic             e_mode, e_preset, e_inv, e_mask;
  logic             cls_win, ps_win, cls_next, shift_raw;

  assign take      = pix_en & line_start;
  assign ofs_now   = take ? '0 : ((ofs_q == OFS_MAX) ? OFS_MAX : ofs_q + 1'b1);

  assign e_cls_on  = take ? cls_on_cfg      : cls_on_q;
  assign e_cls_off = take ? cls_off_cfg     : cls_off_q;
  assign e_ps_on   = take ? ps_on_cfg       : ps_on_q;
  assign e_ps_off  = take ? ps_off_cfg      : ps_off_q;
  assign e_mode    = take ? cls_window_mode : mode_q;
  assign e_preset  = take ? preset_en       : preset_q;
  assign e_inv     = take ? shift_invert    : inv_q;
  assign e_mask    = take ? shift_gate_en   : mask_q;

  assign cls_win   = (ofs_now >= e_cls_on) && (ofs_now <= e_cls_off);
  assign ps_win    = (ofs_now >= e_ps_on)  && (ofs_now <= e_ps_off);
  assign cls_next  = e_mode ? (e_preset & cls_win) : (cls_q ^ take);
  assign shift_raw = pix_en & ~(e_mask & ~disp_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= OFS_MAX;
      cls_q <= 1'b0;
      ps_q  <= 1'b0;
    end else if (pix_en) begin
      ofs_q <= ofs_now;
      cls_q <= cls_next;
      ps_q  <= e_preset & ps_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_on_q  <= '0;
      cls_off_q <= '0;
      ps_on_q   <= '0;
      ps_off_q  <= '0;
      mode_q    <= 1'b0;
      preset_q  <= 1'b0;
      swap_q    <= 1'b0;
      inv_q     <= 1'b0;
      mask_q    <= 1'b0;
    end else if (take) begin
      cls_on_q  <= cls_on_cfg;
      cls_off_q <= cls_off_cfg;
      ps_on_q   <= ps_on_cfg;
      ps_off_q  <= ps_off_cfg;
      mode_q    <= cls_window_mode;
      preset_q  <= preset_en;
      swap_q    <= swap_pins;
      inv_q     <= shift_invert;
      mask_q    <= shift_gate_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shclk_q <= 1'b0;
    else        shclk_q <= shift_raw ^ e_inv;
  end

  assign ctl1_o      = swap_q ? ps_q  : cls_q;
  assign ctl0_o      = swap_q ? cls_q : ps_q;
  assign shift_clk_o = shclk_q;

endmodule

// File: rtl/tft_strobe_gen_chk.sv
module tft_strobe_gen_chk #(
  parameter int OFS_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             line_start,
  input logic             disp_active,
  input logic [OFS_W-1:0] cls_on_cfg,
  input logic [OFS_W-1:0] ps_on_cfg,
  input logic [OFS_W-1:0] ps_off_cfg,
  input logic             cls_window_mode,
  input logic             preset_en,
  input logic             swap_pins,
  input logic             swap_q,
  input logic             inv_q,
  input logic             mask_q,
  input logic             ctl1_o,
  input logic             ctl0_o,
  input logic             shift_clk_o
);

  AST_STROBES_HOLD_OFF_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable({ctl1_o, ctl0_o})); // R2

  AST_LINE_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_start && cls_window_mode && preset_en && cls_on_cfg == '0 && !swap_pins)
    |=> ctl1_o); // R2

  AST_NO_PRESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_start && !preset_en && !swap_pins) |=> !ctl0_o); // R4

  AST_REVERSED_WINDOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_start && (ps_off_cfg < ps_on_cfg) && !swap_pins) |=> !ctl0_o); // R5

  AST_TOGGLE_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_start && !cls_window_mode && !swap_pins && !swap_q)
    |=> (ctl1_o != $past(ctl1_o))); // R6

  AST_SHIFT_EDGE_NEAR_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shift_clk_o) |-> ($past(pix_en) || $past(pix_en, 2))); // R8

  AST_MASKED_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !disp_active && !(pix_en && line_start)) |=> (shift_clk_o == inv_q)); // R9

endmodule

bind tft_strobe_gen tft_strobe_gen_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
  .disp_active(disp_active), .cls_on_cfg(cls_on_cfg), .ps_on_cfg(ps_on_cfg),
  .ps_off_cfg(ps_off_cfg), .cls_window_mode(cls_window_mode), .preset_en(preset_en),
  .swap_pins(swap_pins), .swap_q(swap_q), .inv_q(inv_q), .mask_q(mask_q),
  .ctl1_o(ctl1_o), .ctl0_o(ctl0_o), .shift_clk_o(shift_clk_o)
);

// File: tb/test_tft_strobe_gen.sv
module test_tft_strobe_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, pix_en = 1'b0, line_start = 1'b0, disp_active = 1'b1;
  logic [9:0] cls_on_cfg = '0, cls_off_cfg = '0, ps_on_cfg = '0, ps_off_cfg = '0;
  logic cls_window_mode = 1'b0, preset_en = 1'b0, swap_pins = 1'b0;
  logic shift_invert = 1'b0, shift_gate_en = 1'b0;
  logic ctl1_o, ctl0_o, shift_clk_o;

  int errs = 0, checks = 0;
  logic last_cls = 1'b0;

  tft_strobe_gen i_tft_strobe_gen (.*);

  // {cls_on, cls_off, ps_on, ps_off, mode, preset, swap}
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {10'd3,  10'd7,  10'd10, 10'd12, 1'b1, 1'b1, 1'b0},
    {10'd3,  10'd7,  10'd10, 10'd12, 1'b1, 1'b1, 1'b1},
    {10'd0,  10'd0,  10'd23, 10'd23, 1'b1, 1'b1, 1'b0},
    {10'd2,  10'd9,  10'd4,  10'd6,  1'b1, 1'b0, 1'b0},
    {10'd9,  10'd4,  10'd5,  10'd5,  1'b1, 1'b1, 1'b0},
    {10'd0,  10'd5,  10'd2,  10'd6,  1'b0, 1'b1, 1'b0},
    {10'd0,  10'd5,  10'd8,  10'd8,  1'b0, 1'b1, 1'b1},
    {10'd0,  10'd5,  10'd9,  10'd3,  1'b0, 1'b0, 1'b0},
    {10'd5,  10'd5,  10'd0,  10'd23, 1'b1, 1'b1, 1'b1},
    {10'd1,  10'd22, 10'd7,  10'd7,  1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pixel(input logic ls, output logic c1, output logic c0,
                       output logic shi, output logic slo);
    @(negedge clk); pix_en = 1'b1; line_start = ls;
    @(negedge clk); pix_en = 1'b0; line_start = 1'b0;
    c1 = ctl1_o; c0 = ctl0_o; shi = shift_clk_o;
    @(negedge clk); slo = shift_clk_o;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic c1, c0, shi, slo;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", ctl1_o, 1'b0);
    chk("R11", ctl0_o, 1'b0);
    chk("R11", shift_clk_o, 1'b0);
    rst_n = 1'b1;
    cls_on_cfg = 10'd0; cls_off_cfg = 10'd1023; ps_on_cfg = 10'd0; ps_off_cfg = 10'd1023;
    cls_window_mode = 1'b1; preset_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pixel(1'b0, c1, c0, shi, slo);
      chk("R11", c1, 1'b0);
      chk("R11", c0, 1'b0);
    end

    // Table of whole lines
    for (int v = 0; v < NV; v++) begin
      logic [9:0] con, coff, pon, poff;
      logic md, pr, sw;
      {con, coff, pon, poff, md, pr, sw} = VEC[v];
      cls_on_cfg = con; cls_off_cfg = coff; ps_on_cfg = pon; ps_off_cfg = poff;
      cls_window_mode = md; preset_en = pr; swap_pins = sw;
      for (int p = 0; p < 24; p++) begin
        logic ec, ep;
        pixel(p == 0, c1, c0, shi, slo);
        cls_on_cfg = ~con; ps_off_cfg = ~poff; swap_pins = ~sw;
        if (md) ec = pr && (p >= con) && (p <= coff);
        else    ec = (p == 0) ? ~last_cls : last_cls;
        last_cls = ec;
        ep = pr && (p >= pon) && (p <= poff);
        chk(sw ? "R7" : (!md ? "R6" : (coff < con ? "R5" : (pr ? "R2" : "R4"))),
            c1, sw ? ep : ec);
        chk(sw ? "R7" : (poff < pon ? "R5" : (pr ? "R3" : "R4")),
            c0, sw ? ec : ep);
        chk("R8", shi, 1'b1);
        chk("R8", slo, 1'b0);
      end
    end

    // R1: saturation at 1023
    cls_on_cfg = 10'd1020; cls_off_cfg = 10'd1023; ps_on_cfg = 10'd0; ps_off_cfg = 10'd0;
    cls_window_mode = 1'b1; preset_en = 1'b1; swap_pins = 1'b0;
    for (int p = 0; p < 1030; p++) begin
      pixel(p == 0, c1, c0, shi, slo);
      if (p == 1019) chk("R1", c1, 1'b0);
      if (p == 1020 || p == 1023 || p == 1029) chk("R1", c1, 1'b1);
      if (p == 1029) chk("R1", c0, 1'b0);
    end

    // R10: mid-line change waits for next line
    cls_on_cfg = 10'd20; cls_off_cfg = 10'd21; ps_on_cfg = 10'd2; ps_off_cfg = 10'd4;
    cls_window_mode = 1'b1; preset_en = 1'b1; swap_pins = 1'b0;
    for (int p = 0; p < 13; p++) begin
      pixel(p == 0, c1, c0, shi, slo);
      if (p == 1) begin
        ps_on_cfg = 10'd10; ps_off_cfg = 10'd12; swap_pins = 1'b1; cls_window_mode = 1'b0;
      end
      if (p == 3) begin chk("R10", c0, 1'b1); chk("R10", c1, 1'b0); end
      if (p == 5) chk("R10", c0, 1'b0);
      if (p == 11) chk("R10", c1, 1'b0);
    end
    for (int p = 0; p < 13; p++) begin
      pixel(p == 0, c1, c0, shi, slo);
      if (p == 3)  chk("R10", c1, 1'b0);
      if (p == 10) begin chk("R10", c1, 1'b1); chk("R10", c0, 1'b1); end
    end

    // R8 / R9: shift clock polarity and masking
    shift_invert = 1'b1; shift_gate_en = 1'b0; disp_active = 1'b1;
    pixel(1'b1, c1, c0, shi, slo);
    chk("R8", shi, 1'b0); chk("R8", slo, 1'b1);
    shift_gate_en = 1'b1; disp_active = 1'b0;
    pixel(1'b1, c1, c0, shi, slo);
    chk("R9", shi, 1'b1); chk("R9", slo, 1'b1);
    pixel(1'b0, c1, c0, shi, slo);
    chk("R9", shi, 1'b1);
    disp_active = 1'b1;
    pixel(1'b0, c1, c0, shi, slo);
    chk("R9", shi, 1'b0); chk("R9", slo, 1'b1);
    shift_invert = 1'b0; disp_active = 1'b0;
    pixel(1'b1, c1, c0, shi, slo);
    chk("R9", shi, 1'b0); chk("R9", slo, 1'b0);
    shift_gate_en = 1'b0;
    pixel(1'b1, c1, c0, shi, slo);
    chk("R9", shi, 1'b1); chk("R9", slo, 1'b0);

    finish_run();
  end
endmodule